// File: doc/BRIEF.md
# MMU Control Register Bank

This block sits beside a CPU core and holds the registers that steer address translation and record exception state. They are the MMU control word, the high, low and assist parts of a page-table entry, the translation-table base, the faulting address, and three event-code registers for traps, exceptions and interrupts. Three read-only identification words give the processor version, the cache version and the processor revision.

The bank has one 32-bit access port, addressed by word offset. Accesses are single-cycle requests. A read returns its data, and any access returns its error flag, one clock after the request. The bank does not hold the TLB or perform translation. Instead, it sends two one-cycle pulses to the translation logic. The invalidate pulse follows a control write that sets the invalidate bit. The flush pulse follows a page-table-entry-high write that changes the address-space ID.

Top module: `mmu_reg_bank`

## Requirements
- R1: Offset 0 is the MMU control word. A write with bit 2 set drives `tlb_inv_o` high for exactly one cycle, in the cycle after the write. Bit 2 is never stored and always reads 0. All other bits are stored as written.
- R2: Offset 1 is the page-table-entry high word. Bits 7:0 hold the address-space ID. A write whose bits 7:0 differ from the stored ID drives `tlb_flush_o` high for one cycle, in the cycle after the write. A write with the same ID gives no pulse. The full 32-bit value is stored in both cases.
- R3: Offset 3, the page-table-entry assist register, keeps only bits 3:0 of a write. Its upper bits read 0.
- R4: Offset 6 (trap code), offset 7 (exception event) and offset 8 (interrupt event) keep only bits 10:0 of a write.
- R5: Offset 2 (page-table-entry low), offset 4 (table base) and offset 5 (fault address) store and return all 32 bits.
- R6: Offsets 9, 10 and 11 return the parameters `PROC_VER`, `CACHE_VER` and `PROC_REV`. Writes to these offsets are ignored and raise no error.
- R7: Offsets 12 to 15 are unmapped. An access to one of them sets `err_o` for one cycle, in the cycle after the request. A read there returns 0, and a write there changes no register.
- R8: After reset, every writable register reads 0, and `rdata_o`, `err_o`, `tlb_inv_o` and `tlb_flush_o` are 0.
- R9: Read data appears on `rdata_o` in the cycle after a read request. In any cycle that does not follow a read, `rdata_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| off_i | input | 4 | Word offset inside the bank |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| err_o | output | 1 | Unmapped-offset flag, one cycle |
| tlb_inv_o | output | 1 | Invalidate-all pulse to the TLB |
| tlb_flush_o | output | 1 | Flush pulse on an address-space-ID change |

## Verification
Every result of this bank is due exactly one clock after the request edge. This holds for read data, the error flag and both TLB pulses. The driver applies each access at a falling edge and queues the expected values, tagged with a due cycle one greater than the current one. The monitor compares only at the falling edge of that due cycle. In cycles with nothing due, it checks that neither pulse is high, which confirms that each pulse lasts a single cycle. Back-to-back flush writes check that pulses can repeat on consecutive cycles.

// File: rtl/mmu_regs_pkg.sv
package mmu_regs_pkg;
  localparam int DATA_W   = 32;
  localparam int OFF_W    = 4;
  localparam int NUM_RW   = 9;
  localparam int NUM_RO   = 3;
  localparam int INV_BIT  = 2;
  localparam int ASID_W   = 8;
  localparam int AST_W    = 4;
  localparam int EVT_W    = 11;

  localparam int IDX_CTRL    = 0;
  localparam int IDX_PTE_HI  = 1;
  localparam int IDX_PTE_LO  = 2;
  localparam int IDX_PTE_AST = 3;
  localparam int IDX_BASE    = 4;
  localparam int IDX_FAULT   = 5;
  localparam int IDX_TRAP    = 6;
  localparam int IDX_EXC     = 7;
  localparam int IDX_IRQ     = 8;
  localparam int IDX_RO0     = NUM_RW;
  localparam int IDX_LIMIT   = NUM_RW + NUM_RO;

  function automatic logic [DATA_W-1:0] keep_mask(input int idx);
    logic [DATA_W-1:0] m;
    m = '1;
    if (idx == IDX_CTRL)
      m[INV_BIT] = 1'b0;
    else if (idx == IDX_PTE_AST)
      m = {{(DATA_W-AST_W){1'b0}}, {AST_W{1'b1}}};
    else if (idx == IDX_TRAP || idx == IDX_EXC || idx == IDX_IRQ)
      m = {{(DATA_W-EVT_W){1'b0}}, {EVT_W{1'b1}}};
    return m;
  endfunction
endpackage

// File: rtl/mmu_addr_decode.sv
module mmu_addr_decode
  import mmu_regs_pkg::*;
(
  input  logic             req_i,
  input  logic             we_i,
  input  logic [OFF_W-1:0] off_i,
  output logic [NUM_RW-1:0] rw_sel_o,
  output logic [NUM_RW-1:0] wr_sel_o,
  output logic [NUM_RO-1:0] ro_sel_o,
  output logic             unmapped_o
);
  for (genvar g = 0; g < NUM_RW; g++) begin : g_rw
    assign rw_sel_o[g] = req_i && (off_i == OFF_W'(g));
    assign wr_sel_o[g] = rw_sel_o[g] && we_i;
  end

  for (genvar g = 0; g < NUM_RO; g++) begin : g_ro
    assign ro_sel_o[g] = req_i && (off_i == OFF_W'(IDX_RO0 + g));
  end

  assign unmapped_o = req_i && (off_i >= OFF_W'(IDX_LIMIT));
endmodule

// File: rtl/mmu_field_regs.sv
module mmu_field_regs
  import mmu_regs_pkg::*;
(
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_RW-1:0]              wr_sel_i,
  input  logic [DATA_W-1:0]              wdata_i,
  output logic [NUM_RW-1:0][DATA_W-1:0]  regs_o
);
  for (genvar g = 0; g < NUM_RW; g++) begin : g_reg
    localparam logic [DATA_W-1:0] KEEP = keep_mask(g);
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          q <= '0;
      else if (wr_sel_i[g]) q <= wdata_i & KEEP;
    end
    assign regs_o[g] = q;
  end
endmodule

// File: rtl/mmu_side_effects.sv
module mmu_side_effects
  import mmu_regs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_ctrl_i,
  input  logic              wr_pteh_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ASID_W-1:0] asid_i,
  output logic              inv_o,
  output logic              flush_o
);
  logic inv_q, flush_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inv_q   <= 1'b0;
      flush_q <= 1'b0;
    end else begin
      inv_q   <= wr_ctrl_i && wdata_i[INV_BIT];
      // compare against the ID held before this write lands
      flush_q <= wr_pteh_i && (wdata_i[ASID_W-1:0] != asid_i);
    end
  end

  assign inv_o   = inv_q;
  assign flush_o = flush_q;
endmodule

// File: rtl/mmu_reg_bank.sv
module mmu_reg_bank
  import mmu_regs_pkg::*;
#(
  parameter logic [DATA_W-1:0] PROC_VER  = 32'h0404_0205,
  parameter logic [DATA_W-1:0] CACHE_VER = 32'h2000_0000,
  parameter logic [DATA_W-1:0] PROC_REV  = 32'h0000_0113
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o,
  output logic              tlb_inv_o,
  output logic              tlb_flush_o
);
  localparam logic [NUM_RO-1:0][DATA_W-1:0] RO_VALS = {PROC_REV, CACHE_VER, PROC_VER};

  logic [NUM_RW-1:0]             rw_sel, wr_sel;
  logic [NUM_RO-1:0]             ro_sel;
  logic                          unmapped;
  logic [NUM_RW-1:0][DATA_W-1:0] regs;
  logic [DATA_W-1:0]             rd_val, rdata_q;
  logic                          err_q;

  mmu_addr_decode i_dec (
    .req_i      (req_i),
    .we_i       (we_i),
    .off_i      (off_i),
    .rw_sel_o   (rw_sel),
    .wr_sel_o   (wr_sel),
    .ro_sel_o   (ro_sel),
    .unmapped_o (unmapped)
  );

  mmu_field_regs i_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_sel_i (wr_sel),
    .wdata_i  (wdata_i),
    .regs_o   (regs)
  );

  mmu_side_effects i_fx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_ctrl_i (wr_sel[IDX_CTRL]),
    .wr_pteh_i (wr_sel[IDX_PTE_HI]),
    .wdata_i   (wdata_i),
    .asid_i    (regs[IDX_PTE_HI][ASID_W-1:0]),
    .inv_o     (tlb_inv_o),
    .flush_o   (tlb_flush_o)
  );

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NUM_RW; i++)
      if (rw_sel[i]) rd_val = rd_val | regs[i];
    for (int j = 0; j < NUM_RO; j++)
      if (ro_sel[j]) rd_val = rd_val | RO_VALS[j];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      rdata_q <= (req_i && !we_i) ? rd_val : '0;
      err_q   <= unmapped;
    end
  end

  assign rdata_o = rdata_q;
  assign err_o   = err_q;

  assert_inv_pulse_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && off_i == OFF_W'(IDX_CTRL) && wdata_i[INV_BIT]) |=> tlb_inv_o);
  assert_inv_cause_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tlb_inv_o |-> $past(req_i && we_i && off_i == OFF_W'(IDX_CTRL)));
  assert_ctrl_rd_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && off_i == OFF_W'(IDX_CTRL)) |=> !rdata_o[INV_BIT]);
  assert_flush_cause_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tlb_flush_o |-> $past(req_i && we_i && off_i == OFF_W'(IDX_PTE_HI)));
  assert_ast_trunc_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && off_i == OFF_W'(IDX_PTE_AST)) |=> (rdata_o[DATA_W-1:AST_W] == '0));
  assert_evt_trunc_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && off_i >= OFF_W'(IDX_TRAP) && off_i <= OFF_W'(IDX_IRQ))
    |=> (rdata_o[DATA_W-1:EVT_W] == '0));
  assert_unmapped_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && off_i >= OFF_W'(IDX_LIMIT)) |=> (err_o && rdata_o == '0));
  assert_no_err_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && off_i >= OFF_W'(IDX_LIMIT)) |=> !err_o);
  assert_idle_rdata_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> (rdata_o == '0));
endmodule

// File: tb/test_mmu_reg_bank.sv
module test_mmu_reg_bank;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] PV = 32'h0404_0205;
  localparam logic [31:0] CV = 32'h2000_0000;
  localparam logic [31:0] PR = 32'h0000_0113;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [3:0] off = '0;
  logic [31:0] wdata = '0, rdata;
  logic err, inv, flush;

  always #(CLK_PERIOD/2) clk = ~clk;

  mmu_reg_bank i_mmu_reg_bank (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .off_i(off),
    .wdata_i(wdata), .rdata_o(rdata), .err_o(err),
    .tlb_inv_o(inv), .tlb_flush_o(flush)
  );

  typedef struct {
    int          due;
    int          rq;
    logic [31:0] rd;
    logic        err;
    logic        inv;
    logic        flush;
  } exp_t;

  exp_t exp_q[$];
  int cyc = 0, n_checks = 0, n_fail = 0;
  logic [31:0] mdl [9];
  bit timeout = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // masks written from the requirements: R1 bit2, R3 [3:0], R4 [10:0]
  function automatic logic [31:0] req_mask(int o);
    case (o)
      0: return 32'hFFFF_FFFB;
      3: return 32'h0000_000F;
      6, 7, 8: return 32'h0000_07FF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  task automatic access(input logic w, input int o, input logic [31:0] d, input int rq);
    exp_t e;
    e.due = cyc + 1; e.rq = rq;
    e.rd = '0; e.err = 1'b0; e.inv = 1'b0; e.flush = 1'b0;
    if (o < 9) begin
      if (w) begin
        e.inv   = (o == 0) && d[2];
        e.flush = (o == 1) && (d[7:0] != mdl[1][7:0]);
        mdl[o]  = d & req_mask(o);
      end else e.rd = mdl[o];
    end else if (o < 12) begin
      if (!w) e.rd = (o == 9) ? PV : (o == 10) ? CV : PR;
    end else e.err = 1'b1;
    req = 1'b1; we = w; off = 4'(o); wdata = d;
    exp_q.push_back(e);
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  // monitor: compare each expected item at its due cycle
  initial begin
    forever begin
      @(negedge clk);
      if (rst_ni) begin
        if (exp_q.size() > 0 && exp_q[0].due == cyc) begin
          exp_t e;
          e = exp_q.pop_front();
          n_checks++;
          if (rdata !== e.rd || err !== e.err || inv !== e.inv || flush !== e.flush) begin
            n_fail++;
            $display("FAIL R%0d cyc %0d: rd=%h err=%b inv=%b flush=%b exp rd=%h err=%b inv=%b flush=%b",
                     e.rq, cyc, rdata, err, inv, flush, e.rd, e.err, e.inv, e.flush);
          end
        end else if (exp_q.size() == 0 || exp_q[0].due != cyc) begin
          n_checks++;  // R1 R2 R7 R9: nothing due, so pulses, error and data stay low
          if (inv !== 1'b0 || flush !== 1'b0 || err !== 1'b0 || rdata !== '0) begin
            n_fail++;
            $display("FAIL R9 idle cyc %0d: rd=%h err=%b inv=%b flush=%b exp all 0",
                     cyc, rdata, err, inv, flush);
          end
        end
      end
    end
  end

  task automatic stimulus;
    for (int i = 0; i < 9; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    // R8: outputs at reset
    n_checks++;
    if (rdata !== '0 || err !== 1'b0 || inv !== 1'b0 || flush !== 1'b0) begin
      n_fail++;
      $display("FAIL R8 reset outputs rd=%h err=%b inv=%b flush=%b exp 0", rdata, err, inv, flush);
    end
    rst_ni = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 9; i++) access(0, i, 0, 8);        // R8 registers read 0
    access(1, 0, 32'hFFFF_FFFF, 1);                         // R1 invalidate
    access(0, 0, 0, 1);
    access(1, 0, 32'h0000_0010, 1);                         // R1 no invalidate
    access(0, 0, 0, 1);
    access(1, 1, 32'h1234_5600, 2);                         // R2 same ID, no flush
    access(1, 1, 32'h1234_56AB, 2);                         // R2 flush
    access(0, 1, 0, 2);
    access(1, 1, 32'hFFFF_FFAB, 2);                         // R2 full store, no flush
    access(0, 1, 0, 2);
    access(1, 1, 32'h0000_0001, 2);                         // R2 back-to-back flushes
    access(1, 1, 32'h0000_0002, 2);
    access(1, 3, 32'hFFFF_FFFF, 3);                         // R3
    access(0, 3, 0, 3);
    access(1, 3, 32'hA5A5_A5A6, 3);
    access(0, 3, 0, 3);
    for (int o = 6; o <= 8; o++) begin                      // R4
      access(1, o, 32'hFFFF_FFFF, 4);
      access(0, o, 0, 4);
      access(1, o, 32'hDEAD_BEEF, 4);
      access(0, o, 0, 4);
    end
    access(1, 2, 32'hCAFE_F00D, 5);                         // R5
    access(1, 4, 32'h8000_0001, 5);
    access(1, 5, 32'h7FFF_FFFE, 5);
    access(0, 2, 0, 5);
    access(0, 4, 0, 5);
    access(0, 5, 0, 5);
    for (int o = 9; o <= 11; o++) begin                     // R6
      access(0, o, 0, 6);
      access(1, o, 32'h1111_1111, 6);
      access(0, o, 0, 6);
    end
    for (int o = 12; o <= 15; o++) begin                    // R7
      access(0, o, 0, 7);
      access(1, o, 32'h5555_5555, 7);
    end
    for (int i = 0; i < 9; i++) access(0, i, 0, 7);        // R7 nothing changed
    repeat (4) @(negedge clk);
  endtask

  initial begin
    fork
      stimulus();
      begin
        repeat (20000) @(posedge clk);
        timeout = 1;
      end
    join_any
    disable fork;
    if (timeout) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete");
    end
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule